// File: doc/BRIEF.md
# Serial Display Driver Register Chain

This block is the logic core of a 60-channel display driver. A slow serial interface made of a shift clock, a data line and a latch strobe moves a frame of channel bits into a chain of shift stages. The last stage feeds a serial output, so several drivers can be connected in series. A rising edge on the latch strobe copies the whole chain into a holding register in one step. The channel outputs show the holding register unless one of two override controls is active: a show control whose low level blanks every channel, and a lamp-test control that turns every channel on.

All interface inputs are asynchronous to the block's fast system clock. Each one passes through a two-flop synchronizer. The shift clock and the latch strobe then go through rising-edge detectors, and shifting and latching act on the detected edges. The shift clock may run at up to one quarter of the system clock rate, so a 4 MHz serial rate needs a system clock of at least 16 MHz. A shift clock edge that arrives while the latch strobe is high clears both registers instead of shifting.

Top module: `disp_chain`

## Requirements
- R1: Each detected rising edge of the shift clock moves every stage one place toward channel N. Stage 0 (channel 1, `ch_o[0]`) takes the synchronized data bit. Between edges the chain does not change.
- R2: `sout_o` always equals the last stage (channel N). After N shift edges, the first bit sent appears on `sout_o`, and after a latch it appears on `ch_o[N-1]`.
- R3: On a rising edge of the latch strobe, the holding register loads all N stages. Shifting with the strobe low leaves the channel outputs unchanged.
- R4: A shift clock rising edge while the synchronized latch strobe is high forces every chain stage and every holding bit to 0. This clear takes priority over shifting and latching.
- R5: While `show_i` is low, all N channel outputs are 0, whatever `lamp_test_i` and the held data are.
- R6: While `show_i` is high and `lamp_test_i` is high, all N channel outputs are 1.
- R7: While `show_i` is high and `lamp_test_i` is low, `ch_o[k]` equals holding bit k. A 1 bit means the channel is on.
- R8: Every input is synchronized by two flops. A shift clock held high for many system clocks causes exactly one shift, and an edge detector never pulses on two consecutive cycles.
- R9: A synchronous active-high `rst` clears the synchronizers, the chain, the holding register and the outputs, so that `ch_o` and `sout_o` read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the shift clock rate |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial shift clock, asynchronous |
| sdat_i | input | 1 | Serial data, captured at the shift clock rising edge |
| lstb_i | input | 1 | Latch strobe, asynchronous |
| show_i | input | 1 | Low blanks all channels |
| lamp_test_i | input | 1 | High turns all channels on while shown |
| sout_o | output | 1 | Serial output of the last chain stage |
| ch_o | output | N (60) | Registered channel outputs |

## Verification
The in-line assertions check the following on every cycle:
- the chain and the holding register stay stable when no edge or clear occurs;
- the clear leaves zeros;
- each output override mode (blank, all on, data) drives the value it must;
- edge pulses last a single cycle;
- the reset state.

Some behaviour only the bench scenarios can show: bit ordering across the full 60-stage chain, the arrival of the first bit at the serial output after exactly N edges, and that long shift clock highs shift once. The same holds for the clear triggered by a shift edge during a high strobe. The bench's reference model follows the synchronizer latency and compares the outputs every cycle.

// File: rtl/disp_pkg.sv
package disp_pkg;
  typedef enum logic [1:0] {
    DRV_BLANK  = 2'd0,
    DRV_ALL_ON = 2'd1,
    DRV_DATA   = 2'd2
  } drv_mode_e;
endpackage

// File: rtl/sync_level.sv
module sync_level #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= '0;
      else     pipe <= {pipe[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = pipe[STAGES-1];
  end
endmodule

// File: rtl/sync_edge.sv
module sync_edge #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] lvl;
  logic [WIDTH-1:0] last;

  sync_level #(.WIDTH(WIDTH), .STAGES(STAGES)) u_lvl (
    .clk(clk), .rst(rst), .d_i(d_i), .q_o(lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) last <= '0;
    else     last <= lvl;
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_edge
    assign rise_o[g] = lvl[g] & ~last[g];
    // R8: an edge yields a single-cycle pulse
    assert_one_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/shift_chain.sv
module shift_chain #(
  parameter int N = 60
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv_i,
  input  logic         clr_i,
  input  logic         din_i,
  output logic [N-1:0] q_o,
  output logic         sout_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) q_o <= '0;
    else if (adv_i)   q_o <= {q_o[N-2:0], din_i};
  end

  assign sout_o = q_o[N-1];

  assert_chain_still_R1: assert property (@(posedge clk) disable iff (rst)
    !(adv_i || clr_i) |=> $stable(q_o));
  assert_chain_clear_R4: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (q_o == '0));
endmodule

// File: rtl/hold_reg.sv
module hold_reg #(
  parameter int N = 60
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_i,
  input  logic         clr_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) q_o <= '0;
    else if (ld_i)    q_o <= d_i;
  end

  assert_hold_edge_only_R3: assert property (@(posedge clk) disable iff (rst)
    !(ld_i || clr_i) |=> $stable(q_o));
  assert_hold_clear_R4: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (q_o == '0));
endmodule

// File: rtl/chan_drive.sv
module chan_drive
  import disp_pkg::*;
#(
  parameter int N = 60
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         show_i,
  input  logic         test_i,
  input  logic [N-1:0] hold_i,
  output logic [N-1:0] ch_o
);
  drv_mode_e mode;

  always_comb begin
    if (!show_i)     mode = DRV_BLANK;
    else if (test_i) mode = DRV_ALL_ON;
    else             mode = DRV_DATA;
  end

  always_ff @(posedge clk) begin
    if (rst) ch_o <= '0;
    else begin
      unique case (mode)
        DRV_BLANK:  ch_o <= '0;
        DRV_ALL_ON: ch_o <= '1;
        default:    ch_o <= hold_i;
      endcase
    end
  end

  assert_blank_R5: assert property (@(posedge clk) disable iff (rst)
    !show_i |=> (ch_o == '0));
  assert_all_on_R6: assert property (@(posedge clk) disable iff (rst)
    (show_i && test_i) |=> (ch_o == '1));
  assert_data_R7: assert property (@(posedge clk) disable iff (rst)
    (show_i && !test_i) |=> (ch_o == $past(hold_i)));
endmodule

// File: rtl/disp_chain.sv
module disp_chain #(
  parameter int N      = 60,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk_i,
  input  logic         sdat_i,
  input  logic         lstb_i,
  input  logic         show_i,
  input  logic         lamp_test_i,
  output logic         sout_o,
  output logic [N-1:0] ch_o
);
  localparam int NLVL = 4;
  localparam int NEDG = 2;

  logic [NLVL-1:0] lvl;
  logic [NEDG-1:0] rise;
  logic [N-1:0]    chain_q;
  logic [N-1:0]    hold_q;
  logic            clr;

  // lvl: {lamp test, show, strobe, data}
  sync_level #(.WIDTH(NLVL), .STAGES(STAGES)) u_lvl (
    .clk(clk), .rst(rst),
    .d_i({lamp_test_i, show_i, lstb_i, sdat_i}),
    .q_o(lvl)
  );

  // rise: {strobe, shift clock}
  sync_edge #(.WIDTH(NEDG), .STAGES(STAGES)) u_edge (
    .clk(clk), .rst(rst),
    .d_i({lstb_i, sclk_i}),
    .rise_o(rise)
  );

  assign clr = rise[0] & lvl[1];

  shift_chain #(.N(N)) u_chain (
    .clk(clk), .rst(rst), .adv_i(rise[0]), .clr_i(clr),
    .din_i(lvl[0]), .q_o(chain_q), .sout_o(sout_o)
  );

  hold_reg #(.N(N)) u_hold (
    .clk(clk), .rst(rst), .ld_i(rise[1]), .clr_i(clr),
    .d_i(chain_q), .q_o(hold_q)
  );

  chan_drive #(.N(N)) u_drv (
    .clk(clk), .rst(rst), .show_i(lvl[2]), .test_i(lvl[3]),
    .hold_i(hold_q), .ch_o(ch_o)
  );

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (ch_o == '0 && !sout_o));
endmodule

// File: tb/test_disp_chain.sv
`timescale 1ns/1ps
module test_disp_chain;
  localparam int N = 60;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdat = 1'b0, lstb = 1'b0, show = 1'b0, ltest = 1'b0;
  logic sout;
  logic [N-1:0] ch;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  disp_chain #(.N(N)) i_disp_chain (
    .clk(clk), .rst(rst), .sclk_i(sclk), .sdat_i(sdat), .lstb_i(lstb),
    .show_i(show), .lamp_test_i(ltest), .sout_o(sout), .ch_o(ch)
  );

  // Reference model: inputs seen two system clocks late, edges found from history
  bit hck[4], hls[4], hd[4], hsh[4], hts[4];
  logic [N-1:0] m_sr = '0, m_hold = '0, m_out = '0;

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 4; k++) begin
        hck[k] = 0; hls[k] = 0; hd[k] = 0; hsh[k] = 0; hts[k] = 0;
      end
      m_sr = '0; m_hold = '0; m_out = '0;
    end else begin
      for (int k = 3; k > 0; k--) begin
        hck[k] = hck[k-1]; hls[k] = hls[k-1]; hd[k] = hd[k-1];
        hsh[k] = hsh[k-1]; hts[k] = hts[k-1];
      end
      hck[0] = sclk; hls[0] = lstb; hd[0] = sdat; hsh[0] = show; hts[0] = ltest;
      m_out = !hsh[2] ? '0 : (hts[2] ? '1 : m_hold);
      if (hck[2] && !hck[3] && hls[2]) begin
        m_sr = '0; m_hold = '0;
      end else begin
        if (hls[2] && !hls[3]) m_hold = m_sr;
        if (hck[2] && !hck[3]) m_sr = {m_sr[N-2:0], hd[2]};
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (ch !== m_out) begin
        errors++;
        $display("FAIL R1 R5 R6 R7 model ch: actual %h expected %h", ch, m_out);
      end
      checks++;
      if (sout !== m_sr[N-1]) begin
        errors++;
        $display("FAIL R2 model sout: actual %b expected %b", sout, m_sr[N-1]);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input bit b, input int hi);
    sdat = b; tick(2);
    sclk = 1'b1; tick(hi);
    sclk = 1'b0; tick(1);
  endtask

  task automatic strobe();
    lstb = 1'b1; tick(3);
    lstb = 1'b0; tick(2);
  endtask

  task automatic dchk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit pat_a(input int i);
    return (i % 3 == 0) ^ (i >= 30);
  endfunction
  function automatic bit pat_b(input int i);
    return (i % 5 == 1);
  endfunction

  logic [N-1:0] exp_a, exp_b, exp_a2;

  initial begin
    for (int i = 0; i < N; i++) begin
      exp_a[N-1-i] = pat_a(i);
      exp_b[N-1-i] = pat_b(i);
    end
    exp_a2 = {exp_a[N-2:0], 1'b1};

    tick(5); rst = 1'b0; tick(6);
    dchk("R9 reset ch", ch, '0);
    dchk("R9 reset sout", {{(N-1){1'b0}}, sout}, '0);

    show = 1'b1;
    for (int i = 0; i < N; i++) send(pat_a(i), 2);
    tick(6);
    dchk("R2 first bit at sout after N edges", {{(N-1){1'b0}}, sout}, {{(N-1){1'b0}}, pat_a(0)});
    dchk("R3 no latch edge yet", ch, '0);

    strobe(); tick(6);
    dchk("R7 R1 latched frame A", ch, exp_a);

    send(1'b1, 2); tick(6);
    dchk("R2 second bit at sout", {{(N-1){1'b0}}, sout}, {{(N-1){1'b0}}, pat_a(1)});
    dchk("R3 shift without strobe edge", ch, exp_a);

    strobe(); tick(6);
    dchk("R1 one more shift", ch, exp_a2);

    for (int i = 0; i < N; i++) send(pat_b(i), 9);
    strobe(); tick(6);
    dchk("R8 long highs shift once", ch, exp_b);

    ltest = 1'b1; tick(6);
    dchk("R6 lamp test all on", ch, '1);
    show = 1'b0; tick(6);
    dchk("R5 blank beats lamp test", ch, '0);
    ltest = 1'b0; tick(6);
    dchk("R5 blank with data", ch, '0);
    show = 1'b1; tick(6);
    dchk("R7 data restored", ch, exp_b);

    lstb = 1'b1; tick(3);
    send(1'b1, 2);
    lstb = 1'b0; tick(6);
    dchk("R4 clear holding", ch, '0);
    dchk("R4 clear chain sout", {{(N-1){1'b0}}, sout}, '0);
    strobe(); tick(6);
    dchk("R4 chain empty after clear", ch, '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1'b1;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule